// File: doc/BRIEF.md
# Per-Channel DMA Attribute Register Bank

This block is the software-visible control store of a multi-channel DMA engine. For every channel it keeps five one-bit attributes: channel enable, peripheral request mask, burst-only mode, alternate control-structure select and high priority. Each attribute vector has its own pair of write addresses. Writing ones to the "set" address turns the chosen channels' bits on. Writing ones to the "clear" address turns them off. Software can therefore change single channels without a read-modify-write sequence, and zero bits in a write leave their channels alone.

The block also holds a software request vector, a write-one-to-clear completion status vector with a combined interrupt output, and a bus error flag. It holds a master enable, a control table base pointer and a read-only derived alternate base. The channel sequencer drives strobes that override software:
- a completion strobe clears the channel's enable and raises its status bit;
- a burst-tail strobe drops burst-only mode when fewer items than one burst remain, or after the last burst;
- an alternate strobe selects the alternate structure for ping-pong and scatter-gather cycles;
- a request-done strobe retires the software request.

The bus side is a single-cycle register port. A write takes effect at the clock edge. Read data is a combinational function of the address and the current state.

Top module: `dma_attr_regbank`

## Requirements
- R1: After reset every attribute vector, the software request vector, the status vector, the error flag, the master enable and the base pointer are zero, and `irq_o` is low.
- R2: Set addresses are 0x018 burst-only, 0x020 request mask, 0x028 enable, 0x030 alternate select and 0x038 priority. Writing 1 in bit n sets channel n's bit, writing 0 changes nothing, and reading a set address returns the vector in bits NCH-1:0.
- R3: Each clear address is its set address plus 4. Writing 1 in bit n clears channel n's bit, writing 0 changes nothing, and a clear address reads as zero.
- R4: A pulse on `done_strb[n]` clears channel n's enable bit and sets bit n of the completion status vector.
- R5: A pulse on `burst_tail_strb[n]` clears channel n's burst-only bit.
- R6: A pulse on `alt_flip_strb[n]` sets channel n's alternate-select bit.
- R7: When a hardware strobe and a software write act on the same bit in the same cycle, the hardware action decides the bit's next value.
- R8: The completion status vector reads at 0x504. Writing 1 to bit n clears it, and `irq_o` is high whenever any status bit is set.
- R9: Writing 1 to bit n at 0x014 raises software request n. The vector reads back at 0x014 and is driven on `swreq_o`, and `swreq_done_strb[n]` clears the bit.
- R10: Bit 0 at 0x004 is the master enable (`master_en_o`), read back at 0x004. Offset 0x000 returns the master enable in bit 0 and NCH-1 in bits 20:16.
- R11: Offset 0x008 holds a base pointer whose bits 31:10 are writable and whose bits 9:0 read 0. Offset 0x00C reads that pointer plus 0x200 and ignores writes.
- R12: Offset 0x010 returns the `wait_req` input vector.
- R13: `bus_err_strb` sets the error flag, which reads in bit 0 of 0x04C. Writing 1 to that bit clears the flag.
- R14: Unmapped offsets read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| done_strb | input | NCH | Channel completed its cycle |
| burst_tail_strb | input | NCH | Drop burst-only mode for the channel |
| alt_flip_strb | input | NCH | Select the alternate structure for the channel |
| swreq_done_strb | input | NCH | Software request serviced |
| bus_err_strb | input | 1 | Bus error seen by the engine |
| wait_req | input | NCH | Channel waiting on a request |
| chan_en_o | output | NCH | Enable vector |
| req_mask_o | output | NCH | Request mask vector |
| burst_only_o | output | NCH | Burst-only vector |
| alt_sel_o | output | NCH | Alternate select vector |
| prio_hi_o | output | NCH | High priority vector |
| swreq_o | output | NCH | Software request vector |
| irq_o | output | 1 | Any completion status bit set |
| master_en_o | output | 1 | Master enable |
| ctl_base_o | output | 32 | Control table base pointer |

## Verification
Directed patterns write sparse masks, all-ones and all-zeros to each set and clear address. These separate a correct per-bit update from a whole-word overwrite and show that zero bits leave their channels alone. Same-cycle collisions of each hardware strobe with a software write to the same bit show whether hardware or software decides the bit's next value. Random sequences then mix writes to every set, clear, request and status address with sparse random strobes. They compare all vectors after every step, which exposes cross-talk between attributes and decode aliasing between neighbouring offsets.

// File: rtl/dma_attr_pkg.sv
package dma_attr_pkg;
  localparam int ADDR_W = 12;
  localparam int NATTR  = 5;
  localparam int IDX_W  = $clog2(NATTR);

  // attribute order fixes the set/clear address layout
  typedef enum logic [IDX_W-1:0] {
    AT_BURST = 3'd0,
    AT_MASK  = 3'd1,
    AT_EN    = 3'd2,
    AT_ALT   = 3'd3,
    AT_PRIO  = 3'd4
  } attr_e;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_BASE  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ALT   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_WAIT  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_SWREQ = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_SC0   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_ERR   = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_IRQ   = 12'h504;
  localparam int SC_STRIDE = 8;
  localparam int CLR_GAP   = 4;
  localparam int BASE_LSB  = 10;
  localparam logic [BASE_LSB-1:0] ALT_OFFSET = 10'h200;

  typedef enum logic [3:0] {
    RS_NONE, RS_STAT, RS_CFG, RS_BASE, RS_ALT, RS_WAIT,
    RS_SWREQ, RS_SET, RS_CLR, RS_ERR, RS_IRQ
  } rsel_e;
endpackage

// File: rtl/dma_attr_dec.sv
module dma_attr_dec
  import dma_attr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NATTR-1:0]     set_we,
  output logic [NATTR-1:0]     clr_we,
  output logic                 cfg_we,
  output logic                 base_we,
  output logic                 swreq_we,
  output logic                 err_we,
  output logic                 irq_we,
  output rsel_e                rsel,
  output logic [IDX_W-1:0]     ridx
);
  always_comb begin
    set_we = '0;
    clr_we = '0;
    rsel   = RS_NONE;
    ridx   = '0;
    for (int k = 0; k < NATTR; k++) begin
      if (addr == OFS_SC0 + ADDR_W'(k * SC_STRIDE)) begin
        set_we[k] = wr;
        rsel      = RS_SET;
        ridx      = IDX_W'(k);
      end
      if (addr == OFS_SC0 + ADDR_W'(k * SC_STRIDE + CLR_GAP)) begin
        clr_we[k] = wr;
        rsel      = RS_CLR;
        ridx      = IDX_W'(k);
      end
    end
    case (addr)
      OFS_STAT:  rsel = RS_STAT;
      OFS_CFG:   rsel = RS_CFG;
      OFS_BASE:  rsel = RS_BASE;
      OFS_ALT:   rsel = RS_ALT;
      OFS_WAIT:  rsel = RS_WAIT;
      OFS_SWREQ: rsel = RS_SWREQ;
      OFS_ERR:   rsel = RS_ERR;
      OFS_IRQ:   rsel = RS_IRQ;
      default:   ;
    endcase
    cfg_we   = wr && (addr == OFS_CFG);
    base_we  = wr && (addr == OFS_BASE);
    swreq_we = wr && (addr == OFS_SWREQ);
    err_we   = wr && (addr == OFS_ERR);
    irq_we   = wr && (addr == OFS_IRQ);
  end

  // R14
  wr_decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_we, clr_we, cfg_we, base_we, swreq_we, err_we, irq_we}));
endmodule

// File: rtl/dma_attr_setclr.sv
module dma_attr_setclr #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_set_we,
  input  logic           sw_clr_we,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] hw_set,
  input  logic [NCH-1:0] hw_clr,
  output logic [NCH-1:0] q
);
  logic [NCH-1:0] set_m, clr_m, d;
  logic           en;

  always_comb begin
    set_m = sw_set_we ? wbits : '0;
    clr_m = sw_clr_we ? wbits : '0;
    d     = (((q | set_m) & ~clr_m) | hw_set) & ~hw_clr;
    en    = sw_set_we | sw_clr_we | (|hw_set) | (|hw_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  // R7
  hw_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_clr) |=> ((q & $past(hw_clr)) == '0));
  // R7
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & ~hw_clr)) |=> ((~q & $past(hw_set & ~hw_clr)) == '0));
  // R2
  sw_set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_we |=> ((~q & $past(wbits & ~hw_clr)) == '0));
  // R3
  sw_clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_we |=> ((q & $past(wbits & ~hw_set)) == '0));
  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_set_we || sw_clr_we || (|hw_set) || (|hw_clr)) |=> $stable(q));
endmodule

// File: rtl/dma_attr_w1c.sv
module dma_attr_w1c #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_clr_we,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    d  = (q & ~(sw_clr_we ? wbits : '0)) | hw_set;
    en = sw_clr_we | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  // R7
  w1c_hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((~q & $past(hw_set)) == '0));
  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_we |=> ((q & $past(wbits & ~hw_set)) == '0));
endmodule

// File: rtl/dma_attr_regbank.sv
module dma_attr_regbank
  import dma_attr_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    done_strb,
  input  logic [NCH-1:0]    burst_tail_strb,
  input  logic [NCH-1:0]    alt_flip_strb,
  input  logic [NCH-1:0]    swreq_done_strb,
  input  logic              bus_err_strb,
  input  logic [NCH-1:0]    wait_req,
  output logic [NCH-1:0]    chan_en_o,
  output logic [NCH-1:0]    req_mask_o,
  output logic [NCH-1:0]    burst_only_o,
  output logic [NCH-1:0]    alt_sel_o,
  output logic [NCH-1:0]    prio_hi_o,
  output logic [NCH-1:0]    swreq_o,
  output logic              irq_o,
  output logic              master_en_o,
  output logic [DW-1:0]     ctl_base_o
);
  localparam int CNT_LSB = 16;
  localparam int CNT_W   = 5;
  localparam int BASE_W  = DW - BASE_LSB;

  logic [NATTR-1:0]          set_we, clr_we;
  logic                      cfg_we, base_we, swreq_we, err_we, irq_we;
  rsel_e                     rsel;
  logic [IDX_W-1:0]          ridx;
  logic [NATTR-1:0][NCH-1:0] attr_q, hw_set_a, hw_clr_a;
  logic [NCH-1:0]            irq_q;
  logic [0:0]                err_q;
  logic                      men_q, men_d;
  logic [BASE_W-1:0]         base_q, base_d;
  logic [DW-1:0]             alt_base;

  dma_attr_dec u_dec (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .set_we(set_we), .clr_we(clr_we), .cfg_we(cfg_we), .base_we(base_we),
    .swreq_we(swreq_we), .err_we(err_we), .irq_we(irq_we),
    .rsel(rsel), .ridx(ridx)
  );

  // hardware overrides routed per attribute
  always_comb begin
    hw_set_a = '0;
    hw_clr_a = '0;
    hw_clr_a[AT_BURST] = burst_tail_strb;
    hw_clr_a[AT_EN]    = done_strb;
    hw_set_a[AT_ALT]   = alt_flip_strb;
  end

  for (genvar k = 0; k < NATTR; k++) begin : g_attr
    dma_attr_setclr #(.NCH(NCH)) u_vec (
      .clk(clk), .rst_n(rst_n),
      .sw_set_we(set_we[k]), .sw_clr_we(clr_we[k]),
      .wbits(bus_wdata[NCH-1:0]),
      .hw_set(hw_set_a[k]), .hw_clr(hw_clr_a[k]),
      .q(attr_q[k])
    );
  end

  dma_attr_setclr #(.NCH(NCH)) u_swreq (
    .clk(clk), .rst_n(rst_n),
    .sw_set_we(swreq_we), .sw_clr_we(1'b0),
    .wbits(bus_wdata[NCH-1:0]),
    .hw_set('0), .hw_clr(swreq_done_strb),
    .q(swreq_o)
  );

  dma_attr_w1c #(.W(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .sw_clr_we(irq_we),
    .wbits(bus_wdata[NCH-1:0]), .hw_set(done_strb), .q(irq_q)
  );

  dma_attr_w1c #(.W(1)) u_err (
    .clk(clk), .rst_n(rst_n), .sw_clr_we(err_we),
    .wbits(bus_wdata[0:0]), .hw_set(bus_err_strb), .q(err_q)
  );

  // configuration next state
  always_comb begin
    men_d  = cfg_we  ? bus_wdata[0]           : men_q;
    base_d = base_we ? bus_wdata[DW-1:BASE_LSB] : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q  <= 1'b0;
      base_q <= '0;
    end else begin
      men_q  <= men_d;
      base_q <= base_d;
    end
  end

  always_comb begin
    ctl_base_o = {base_q, {BASE_LSB{1'b0}}};
    alt_base   = ctl_base_o + DW'(ALT_OFFSET);
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (rsel)
      RS_STAT: begin
        bus_rdata[0] = men_q;
        bus_rdata[CNT_LSB +: CNT_W] = CNT_W'(NCH - 1);
      end
      RS_CFG:   bus_rdata[0] = men_q;
      RS_BASE:  bus_rdata = ctl_base_o;
      RS_ALT:   bus_rdata = alt_base;
      RS_WAIT:  bus_rdata[NCH-1:0] = wait_req;
      RS_SWREQ: bus_rdata[NCH-1:0] = swreq_o;
      RS_SET:   bus_rdata[NCH-1:0] = attr_q[ridx];
      RS_ERR:   bus_rdata[0] = err_q[0];
      RS_IRQ:   bus_rdata[NCH-1:0] = irq_q;
      default:  bus_rdata = '0;
    endcase
  end

  always_comb begin
    burst_only_o = attr_q[AT_BURST];
    req_mask_o   = attr_q[AT_MASK];
    chan_en_o    = attr_q[AT_EN];
    alt_sel_o    = attr_q[AT_ALT];
    prio_hi_o    = attr_q[AT_PRIO];
    irq_o        = |irq_q;
    master_en_o  = men_q;
  end

  // R4
  done_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_strb) |=> (((chan_en_o & $past(done_strb)) == '0) && irq_o));
  // R11
  alt_base_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_ALT) |-> (bus_rdata[BASE_LSB-1:0] == ALT_OFFSET));
  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_strb |=> err_q[0]);
endmodule

// File: tb/dma_attr_regbank_bench.sv
module dma_attr_regbank_bench;
  localparam int NCH = 32;
  localparam logic [11:0] SC0 = 12'h018;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] done_strb, burst_tail_strb, alt_flip_strb, swreq_done_strb, wait_req;
  logic        bus_err_strb;
  logic [31:0] chan_en_o, req_mask_o, burst_only_o, alt_sel_o, prio_hi_o, swreq_o;
  logic        irq_o, master_en_o;
  logic [31:0] ctl_base_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_attr [5];
  logic [31:0] m_swreq, m_irq;

  always #2 clk = ~clk;

  dma_attr_regbank u_dma_attr_regbank (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_addr = 12'h0FC; bus_wdata = '0;
    done_strb = '0; burst_tail_strb = '0; alt_flip_strb = '0;
    swreq_done_strb = '0; bus_err_strb = 0;
  endtask

  // drive at negedge, capture at posedge, release at next negedge
  task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] dn, input logic [31:0] bt,
                      input logic [31:0] af, input logic [31:0] sd, input logic er);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    done_strb = dn; burst_tail_strb = bt; alt_flip_strb = af;
    swreq_done_strb = sd; bus_err_strb = er;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  // requirement rule for one set/clear vector with hardware overrides
  function automatic logic [31:0] upd(input logic [31:0] q, input logic [31:0] s,
      input logic [31:0] c, input logic [31:0] hs, input logic [31:0] hc);
    return (((q | s) & ~c) | hs) & ~hc;
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      rd(SC0 + 12'(8 * k), v);
      chk({tag, " R2 attr readback"}, v, m_attr[k]);
    end
    rd(12'h014, v); chk({tag, " R9 swreq"}, v, m_swreq);
    rd(12'h504, v); chk({tag, " R8 irq stat"}, v, m_irq);
    chk({tag, " R8 irq_o"}, {31'd0, irq_o}, {31'd0, |m_irq});
    chk({tag, " R4 chan_en_o"}, chan_en_o, m_attr[2]);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    idle();
    wait_req = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 5; k++) m_attr[k] = '0;
    m_swreq = '0; m_irq = '0;

    // R1 reset state
    check_all("R1");
    rd(12'h000, v); chk("R1 R10 status", v, 32'h001F_0000);
    rd(12'h004, v); chk("R1 cfg", v, 0);
    rd(12'h008, v); chk("R1 base", v, 0);
    rd(12'h00C, v); chk("R1 R11 alt base", v, 32'h200);
    rd(12'h04C, v); chk("R1 err", v, 0);

    // R2 set with sparse mask, zero write has no effect
    step(1, 12'h028, 32'hA500_0081, 0, 0, 0, 0, 0);
    rd(12'h028, v); chk("R2 enable set", v, 32'hA500_0081);
    step(1, 12'h028, 32'h0, 0, 0, 0, 0, 0);
    rd(12'h028, v); chk("R2 zero write ignored", v, 32'hA500_0081);
    // R3 clear, read of clear address is zero, zero write ignored
    step(1, 12'h02C, 32'h8000_0001, 0, 0, 0, 0, 0);
    rd(12'h028, v); chk("R3 enable clear", v, 32'h2500_0080);
    rd(12'h02C, v); chk("R3 clear addr reads 0", v, 0);
    step(1, 12'h02C, 32'h0, 0, 0, 0, 0, 0);
    rd(12'h028, v); chk("R3 zero clear ignored", v, 32'h2500_0080);
    m_attr[2] = 32'h2500_0080;

    // R4 completion strobe, R7 collision with enable set
    step(1, 12'h028, 32'h0000_0008, 32'h0000_0088, 0, 0, 0, 0);
    rd(12'h028, v); chk("R4 R7 done clears enable", v, 32'h2500_0000);
    rd(12'h504, v); chk("R4 status set", v, 32'h0000_0088);
    chk("R8 irq_o high", {31'd0, irq_o}, 32'd1);
    m_attr[2] = 32'h2500_0000; m_irq = 32'h88;
    // R8 W1C
    step(1, 12'h504, 32'h0000_0080, 0, 0, 0, 0, 0);
    rd(12'h504, v); chk("R8 w1c partial", v, 32'h8);
    step(1, 12'h504, 32'h0000_0008, 0, 0, 0, 0, 0);
    chk("R8 irq_o low", {31'd0, irq_o}, 0);
    m_irq = 0;

    // R5 burst tail strobe vs same-cycle set (R7)
    step(1, 12'h018, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    step(1, 12'h018, 32'h0000_0010, 0, 32'h0000_0030, 0, 0, 0);
    rd(12'h018, v); chk("R5 R7 burst tail clears", v, 32'hFFFF_FFCF);
    m_attr[0] = 32'hFFFF_FFCF;
    // R6 alt strobe vs same-cycle clear (R7)
    step(1, 12'h034, 32'h0000_0006, 0, 0, 32'h0000_0002, 0, 0);
    rd(12'h030, v); chk("R6 R7 alt set wins", v, 32'h2);
    m_attr[3] = 32'h2;

    // R9 software request
    step(1, 12'h014, 32'h0000_F00F, 0, 0, 0, 0, 0);
    chk("R9 swreq_o", swreq_o, 32'h0000_F00F);
    step(0, 12'h014, 0, 0, 0, 0, 32'h0000_000F, 0);
    rd(12'h014, v); chk("R9 swreq retired", v, 32'h0000_F000);
    m_swreq = 32'h0000_F000;

    // R10 master enable
    step(1, 12'h004, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    rd(12'h004, v); chk("R10 cfg", v, 1);
    rd(12'h000, v); chk("R10 status", v, 32'h001F_0001);
    chk("R10 master_en_o", {31'd0, master_en_o}, 1);
    // R11 base and derived alternate base
    step(1, 12'h008, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    rd(12'h008, v); chk("R11 base", v, 32'hFFFF_FC00);
    rd(12'h00C, v); chk("R11 alt base", v, 32'hFFFF_FE00);
    step(1, 12'h00C, 32'h1234_5678, 0, 0, 0, 0, 0);
    rd(12'h008, v); chk("R11 alt write ignored", v, 32'hFFFF_FC00);
    // R12 wait status
    wait_req = 32'h5A5A_0F0F;
    rd(12'h010, v); chk("R12 wait", v, 32'h5A5A_0F0F);
    // R13 error flag
    step(0, 12'h0FC, 0, 0, 0, 0, 0, 1);
    rd(12'h04C, v); chk("R13 err set", v, 1);
    step(1, 12'h04C, 32'h1, 0, 0, 0, 0, 1);
    rd(12'h04C, v); chk("R13 R7 err strobe wins", v, 1);
    step(1, 12'h04C, 32'h1, 0, 0, 0, 0, 0);
    rd(12'h04C, v); chk("R13 err cleared", v, 0);
    // R14 unmapped
    rd(12'h040, v); chk("R14 unmapped read", v, 0);
    step(1, 12'h044, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    step(1, 12'h500, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    check_all("R14 unmapped write");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int unsigned sel;
      logic [31:0] d, dn, bt, af, sd;
      logic [11:0] a;
      sel = $urandom % 12;
      d  = $urandom;
      dn = $urandom & $urandom & $urandom;
      bt = $urandom & $urandom & $urandom;
      af = $urandom & $urandom & $urandom;
      sd = $urandom & $urandom;
      if (sel < 10) a = SC0 + 12'(4 * sel);
      else if (sel == 10) a = 12'h014;
      else a = 12'h504;
      for (int k = 0; k < 5; k++) begin
        logic [31:0] s, c, hs, hc;
        s  = (sel == 2 * k)     ? d : '0;
        c  = (sel == 2 * k + 1) ? d : '0;
        hs = (k == 3) ? af : '0;
        hc = (k == 0) ? bt : (k == 2) ? dn : '0;
        m_attr[k] = upd(m_attr[k], s, c, hs, hc);
      end
      m_swreq = upd(m_swreq, (sel == 10) ? d : '0, '0, '0, sd);
      m_irq   = (m_irq & ~((sel == 11) ? d : '0)) | dn;
      step(1, a, d, dn, bt, af, sd, 0);
      check_all("random R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule